// File: doc/BRIEF.md
# Dual-Path SPI Serial-Clock Divider

This block derives the serial-clock timing of an SPI controller from the core clock. It does not make a second clock. It makes a one-cycle enable `tick_o` at twice the serial-clock rate, so that the shifter can act on every SCK edge, and it drives the serial-clock level `sck_o` itself. There are two divider families, and a select input picks one of them at run time. The power-of-two path has a fixed divide by 4 followed by a divide by 2^N. The linear path has a fixed divide by 2 followed by a divide by (M+1).

The divider settings and the path select are captured only while no burst is running. A burst therefore always runs at one rate from its first word to its last. While no burst is active, no tick is produced and SCK rests at the programmed clock polarity.

Top module: `sck_clkdiv`

## Requirements
- R1: With `lin_path_i` = 0 (power-of-two path), `tick_o` fires once every 2^(N+1) core cycles during a burst, where N = `rate_exp_i` (3 bits). SCK is then core/(4·2^N), so N = 0, 1, 2, 3 give divide by 4, 8, 16, 32, and N = 7 gives divide by 512.
- R2: With `lin_path_i` = 1 (linear path), `tick_o` fires once every M+1 core cycles during a burst, where M = `rate_lin_i` (8 bits). SCK is then core/(2·(M+1)).
- R3: On the linear path with M = 0, `tick_o` is high on every core cycle of a burst.
- R4: Only the selected path sets the rate. The rate input of the unselected path has no effect.
- R5: `rate_exp_i`, `rate_lin_i` and `lin_path_i` are captured only on clock edges where `burst_i` is low. Changes made while a burst is running have no effect until the next burst.
- R6: The tick counter restarts at every burst. Counting the first core cycle with `burst_i` high as cycle 0, the first tick occurs in cycle P−1, where P is the tick period.
- R7: During a burst, `sck_o` inverts on the clock edge that ends each tick cycle.
- R8: When `burst_i` is low, `tick_o` is low, and from the next edge on `sck_o` equals `cpol_i`.
- R9: While `rst_ni` is low, `tick_o` and `sck_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_i | input | 1 | High while a burst is in progress |
| lin_path_i | input | 1 | 1 selects the linear path, 0 the power-of-two path |
| rate_exp_i | input | 3 | Power-of-two exponent N |
| rate_lin_i | input | 8 | Linear divisor term M |
| cpol_i | input | 1 | Idle level of SCK |
| tick_o | output | 1 | One-cycle enable at twice the SCK rate |
| sck_o | output | 1 | Serial-clock level |

## Verification
The bench aims at the extreme rates and at the edges of a burst: N = 7, M = 255 and M = 0. A divider with an off-by-one error, or one that drops the fixed pre-divide, shows the wrong number of ticks in a fixed window. It reprograms the rate and the path select in the middle of a burst. A design without capture at the burst boundary changes its period in the middle of the burst, and the tick count shows this. It checks where the first tick of each burst falls, and it checks the SCK level after a burst with an odd number of ticks. A counter that is not restarted would move the first edge, and a level generator that does not return to the programmed polarity would leave SCK inverted while idle.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;
  typedef enum logic {
    PATH_POW2 = 1'b0,
    PATH_LIN  = 1'b1
  } path_e;
endpackage

// File: rtl/sck_cfg_hold.sv
module sck_cfg_hold
  import sck_div_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int LIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LIN_W-1:0] lin_i,
  input  logic             sel_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [LIN_W-1:0] lin_o,
  output path_e            path_o
);
  // settings only move while no burst runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_o  <= '0;
      lin_o  <= '0;
      path_o <= PATH_POW2;
    end else if (!busy_i) begin
      exp_o  <= exp_i;
      lin_o  <= lin_i;
      path_o <= path_e'(sel_i);
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> ($stable(exp_o) && $stable(lin_o) && $stable(path_o))); // R5
endmodule

// File: rtl/sck_period_sel.sv
module sck_period_sel
  import sck_div_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int LIN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LIN_W-1:0] lin_i,
  input  path_e            path_i,
  output logic [CNT_W-1:0] lim_o
);
  logic [CNT_W:0]   pow2_span;
  logic [CNT_W-1:0] lim_pow2;
  logic [CNT_W-1:0] lim_lin;

  // tick period 2^(N+1) -> terminal count 2^(N+1)-1
  always_comb begin
    pow2_span = (CNT_W+1)'(2) << exp_i;
    lim_pow2  = CNT_W'(pow2_span - (CNT_W+1)'(1));
    lim_lin   = CNT_W'(lin_i);
  end

  assign lim_o = (path_i == PATH_LIN) ? lim_lin : lim_pow2;
endmodule

// File: rtl/sck_tick_gen.sv
module sck_tick_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= lim_i)); // R6
  AST_BURST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !$past(run_i)) |-> (cnt_q == '0)); // R6
endmodule

// File: rtl/sck_level_gen.sv
module sck_level_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic cpol_i,
  output logic sck_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sck_o <= 1'b0;
    else if (!run_i) sck_o <= cpol_i;
    else if (tick_i) sck_o <= ~sck_o;
  end

  AST_EDGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i) |=> (sck_o != $past(sck_o))); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(sck_o)); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sck_o == $past(cpol_i))); // R8
endmodule

// File: rtl/sck_clkdiv.sv
module sck_clkdiv
  import sck_div_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int LIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_i,
  input  logic             lin_path_i,
  input  logic [EXP_W-1:0] rate_exp_i,
  input  logic [LIN_W-1:0] rate_lin_i,
  input  logic             cpol_i,
  output logic             tick_o,
  output logic             sck_o
);
  localparam int POW_W = 2 ** EXP_W;
  localparam int CNT_W = (POW_W > LIN_W) ? POW_W : LIN_W;

  logic [EXP_W-1:0] exp_sh;
  logic [LIN_W-1:0] lin_sh;
  path_e            path_sh;
  logic [CNT_W-1:0] lim;

  sck_cfg_hold #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (burst_i),
    .exp_i  (rate_exp_i),
    .lin_i  (rate_lin_i),
    .sel_i  (lin_path_i),
    .exp_o  (exp_sh),
    .lin_o  (lin_sh),
    .path_o (path_sh)
  );

  sck_period_sel #(.EXP_W(EXP_W), .LIN_W(LIN_W), .CNT_W(CNT_W)) u_sel (
    .exp_i  (exp_sh),
    .lin_i  (lin_sh),
    .path_i (path_sh),
    .lim_o  (lim)
  );

  sck_tick_gen #(.CNT_W(CNT_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (burst_i),
    .lim_i  (lim),
    .tick_o (tick_o)
  );

  sck_level_gen u_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (burst_i),
    .tick_i (tick_o),
    .cpol_i (cpol_i),
    .sck_o  (sck_o)
  );

  AST_M0_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && path_sh == PATH_LIN && lin_sh == '0) |-> tick_o); // R3
  AST_NO_IDLE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_i |-> !tick_o); // R8
  AST_POW2_NOT_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && path_sh == PATH_POW2 && tick_o) |=> !tick_o); // R1
endmodule

// File: tb/sck_clkdiv_tb_top.sv
`timescale 1ns/1ps
module sck_clkdiv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst = 1'b0;
  logic       sel = 1'b0;
  logic [2:0] exp_v = 3'd0;
  logic [7:0] lin_v = 8'd0;
  logic       cpol = 1'b0;
  logic       tick, sck;

  always #2.5 clk = ~clk;

  sck_clkdiv dut_i (
    .clk_i(clk), .rst_ni(rst_n), .burst_i(burst), .lin_path_i(sel),
    .rate_exp_i(exp_v), .rate_lin_i(lin_v), .cpol_i(cpol),
    .tick_o(tick), .sck_o(sck)
  );

  typedef struct {
    bit    tick;
    bit    sck;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0, n_bad = 0, tick_seen = 0;
  string cur_tag = "R9";

  // reference state
  int m_cnt = 0, m_lim = 1;
  bit m_sck = 0, prev_act = 0, prev_tick = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: one core cycle, pushes the expected outputs for it
  task automatic step(bit act);
    exp_t e;
    @(posedge clk);
    if (!prev_act) begin
      m_lim = sel ? int'(lin_v) : (2 << int'(exp_v)) - 1;
      m_cnt = 0;
      m_sck = cpol;
    end else if (prev_tick) begin
      m_cnt = 0;
      m_sck = ~m_sck;
    end else begin
      m_cnt++;
    end
    #1;
    burst = act;
    e.tick = act && (m_cnt == m_lim);
    e.sck  = m_sck;
    e.tag  = cur_tag;
    q.push_back(e);
    prev_act  = act;
    prev_tick = e.tick;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (tick) tick_seen++;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(tick == e.tick, {e.tag, " tick"}, int'(tick), int'(e.tick));
        chk(sck == e.sck, {e.tag, " sck"}, int'(sck), int'(e.sck));
      end
    end
  end

  task automatic burst_count(string tag, int len, int expect_ticks);
    cur_tag = tag;
    tick_seen = 0;
    for (int i = 0; i < len; i++) step(1'b1);
    step(1'b0);
    @(negedge clk); #0.5;
    chk(tick_seen == expect_ticks, {tag, " tick count"}, tick_seen, expect_ticks);
    step(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(tick == 1'b0, "R9 reset tick", int'(tick), 0);
    chk(sck == 1'b0, "R9 reset sck", int'(sck), 0);
    rst_n = 1'b1;
    step(1'b0); step(1'b0);

    // R1 power-of-two path
    sel = 0; exp_v = 3'd0; step(1'b0);
    burst_count("R1 N0", 16, 8);
    exp_v = 3'd2; step(1'b0);
    burst_count("R1 N2", 40, 5);
    exp_v = 3'd7; step(1'b0);
    burst_count("R1 N7", 520, 2);

    // R2 linear path
    sel = 1; lin_v = 8'd5; step(1'b0);
    burst_count("R2 M5", 30, 5);
    lin_v = 8'd255; step(1'b0);
    burst_count("R2 M255", 300, 1);

    // R3 M zero
    lin_v = 8'd0; step(1'b0);
    burst_count("R3 M0", 10, 10);

    // R4 unselected path has no effect
    sel = 1; lin_v = 8'd3; exp_v = 3'd7; step(1'b0);
    burst_count("R4 lin sel exp7", 20, 5);
    sel = 0; exp_v = 3'd1; lin_v = 8'd0; step(1'b0);
    burst_count("R4 pow2 sel lin0", 20, 5);

    // R5 mid-burst reprogramming ignored until next burst
    exp_v = 3'd0; step(1'b0);
    cur_tag = "R5 midburst";
    tick_seen = 0;
    for (int i = 0; i < 4; i++) step(1'b1);
    sel = 1; lin_v = 8'd9; exp_v = 3'd5;
    for (int i = 0; i < 16; i++) step(1'b1);
    step(1'b0);
    @(negedge clk); #0.5;
    chk(tick_seen == 10, "R5 midburst tick count", tick_seen, 10);
    step(1'b0);
    burst_count("R5 next burst", 20, 2);

    // R6 first tick position
    sel = 0; exp_v = 3'd1; step(1'b0);
    burst_count("R6 short3", 3, 0);
    burst_count("R6 short4", 4, 1);

    // R7 / R8 polarity and idle return after odd tick count
    cpol = 1; exp_v = 3'd0; step(1'b0); step(1'b0);
    chk(sck == 1'b1, "R8 idle cpol1", int'(sck), 1);
    burst_count("R7 odd ticks", 6, 3);
    step(1'b0);
    @(negedge clk); #0.5;
    chk(sck == 1'b1, "R8 idle after burst", int'(sck), 1);
    chk(tick == 1'b0, "R8 idle no tick", int'(tick), 0);
    cpol = 0; step(1'b0); step(1'b0);
    @(negedge clk); #0.5;
    chk(sck == 1'b0, "R8 idle cpol0", int'(sck), 0);

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule